// File: doc/BRIEF.md
# Dithered 12-bit PWM Channel

This block is one pulse-width modulation channel that reaches 12-bit duty resolution from an 8-bit base modulator and a 4-bit rate multiplier. A full output period is split into 16 equal subsections of 256 ticks each. The upper duty bits set the high time of every subsection. The lower duty bits pick a bit-reversed set of subsections that stay high for one extra tick. The result spreads the fine part of the duty value evenly over the period, so a simple low-pass filter on the output gives a smooth analog level.

The channel advances only on clock edges where a tick enable is high. A divide-by-two enable shared by several channels is the intended source. The duty value is copied into a working register only at a cycle boundary, so a write never disturbs the period in progress. A shared restart strobe lets several channels begin their periods on the same tick. The output shows the current subsection index so that neighbours and observers can follow the period.

Top module: `dither_pwm_chan`

## Requirements
- R1: `sub_idx_o` starts at 0, holds for 2^BASE_W ticks, then steps by one; after subsection 2^FRAC_W-1 it wraps to 0, so a period is 2^(BASE_W+FRAC_W) ticks.
- R2: Counters and outputs advance only on rising clock edges where `tick_en` is 1; when `tick_en` is 0, `sub_idx_o` and `pwm_o` hold.
- R3: Within a subsection with working duty d, `pwm_o` is 1 for tick positions 0 to W-1 and 0 for the rest of the subsection. W is d[DUTY_W-1:FRAC_W] plus one when the subsection is extended. W = 0 gives a subsection that is low throughout.
- R4: For FRAC_W = 4, subsection m is extended when (d[3] and m odd) or (d[2] and m mod 4 = 2) or (d[1] and m mod 8 = 4) or (d[0] and m = 8). Subsection 0 is never extended.
- R5: `duty_in` is copied to the working duty only when subsection 2^FRAC_W-1 ends or a restart takes place; a change in the middle of a period alters only the next period.
- R6: When `sync_i` and `tick_en` are both 1 on a clock edge, the next tick is tick 0 of subsection 0, and `duty_in` is loaded as the working duty.
- R7: After reset, `sub_idx_o` is 0 and the working duty is 0, so `pwm_o` stays 0 for the whole first period whatever `duty_in` holds.
- R8: The output is never high for a whole period: the last tick of subsection 0 is always low. With the low duty bits at zero, every subsection has the same high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Tick enable; the channel moves one tick on edges where it is 1 |
| sync_i | input | 1 | Shared restart strobe, acted on together with `tick_en` |
| duty_in | input | BASE_W+FRAC_W | Requested duty value, high part is base width, low part the dither bits |
| pwm_o | output | 1 | Modulated output level |
| sub_idx_o | output | FRAC_W | Index of the current subsection |

## Verification
The bench builds the channel with BASE_W = 5 and FRAC_W = 4, so a period lasts 512 ticks while the 16-subsection dither pattern stays the same as in the default build. This short period lets many periods run, with duty writes at random points, restarts and gaps in the tick enable, and all of it is checked against a tick-by-tick model. It also makes the extreme duty values cheap to visit: a low base with a single dither bit, all dither bits with the largest base, and the all-zero value.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    // Default geometry of one channel: 2^BASE ticks per subsection,
    // 2^FRAC subsections per period.
    localparam int unsigned DPC_BASE_W_DEF = 8;
    localparam int unsigned DPC_FRAC_W_DEF = 4;
endpackage

// File: rtl/dpc_timebase.sv
module dpc_timebase #(
    parameter int unsigned BASE_W = 8,
    parameter int unsigned FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              sync_i,
    output logic [BASE_W-1:0] pos_o,
    output logic [FRAC_W-1:0] sub_o,
    output logic              load_o
);
    localparam logic [BASE_W-1:0] POS_MAX = {BASE_W{1'b1}};
    localparam logic [FRAC_W-1:0] SUB_MAX = {FRAC_W{1'b1}};

    typedef struct packed {
        logic [BASE_W-1:0] pos;
        logic [FRAC_W-1:0] sub;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      load_d;

    always_comb begin
        st_d   = st_q;
        load_d = 1'b0;
        if (tick_en) begin
            if (sync_i || (st_q.pos == POS_MAX && st_q.sub == SUB_MAX)) begin
                st_d   = '0;
                load_d = 1'b1;
            end else if (st_q.pos == POS_MAX) begin
                st_d.pos = '0;
                st_d.sub = st_q.sub + 1'b1;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos_o  = st_q.pos;
    assign sub_o  = st_q.sub;
    assign load_o = load_d;

    // R2: no movement without a tick
    a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(st_q));

    // R1: subsection steps after its last tick
    a_r1_sub_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !sync_i && st_q.pos == POS_MAX)
        |=> st_q.sub == FRAC_W'($past(st_q.sub) + 1'b1));

    // R6: restart lands on tick 0 of subsection 0
    a_r6_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && sync_i) |=> (st_q.pos == '0 && st_q.sub == '0));
endmodule

// File: rtl/dpc_ratemul.sv
module dpc_ratemul #(
    parameter int unsigned FRAC_W = 4
) (
    input  logic [FRAC_W-1:0] sub_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              ext_o
);
    // Dither bit k serves the subsections whose lowest set index bit is
    // FRAC_W-1-k: the top dither bit takes every odd subsection, the
    // bottom one takes only the middle subsection.
    logic [FRAC_W-1:0] hit;

    for (genvar k = 0; k < FRAC_W; k++) begin : g_weight
        localparam int unsigned P = FRAC_W - 1 - k;
        if (P == 0) begin : g_odd
            assign hit[k] = frac_i[k] & sub_i[0];
        end else begin : g_even
            assign hit[k] = frac_i[k] & sub_i[P] & (sub_i[P-1:0] == '0);
        end
    end

    assign ext_o = |hit;

    // R4: subsection 0 never receives the extra tick
    always_comb begin
        a_r4_sub0_plain: assert (!(sub_i == '0 && ext_o));
    end
endmodule

// File: rtl/dpc_shaper.sv
module dpc_shaper #(
    parameter int unsigned BASE_W = 8,
    parameter int unsigned FRAC_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic [BASE_W+FRAC_W-1:0] duty_in,
    input  logic [BASE_W-1:0]        pos_i,
    input  logic                     ext_i,
    output logic [FRAC_W-1:0]        frac_o,
    output logic                     pwm_o
);
    localparam int unsigned DUTY_W = BASE_W + FRAC_W;

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
    } sh_state_t;

    sh_state_t       st_d, st_q;
    logic [BASE_W:0] width;

    always_comb begin
        st_d = st_q;
        if (load_i) st_d.duty = duty_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign width  = {1'b0, st_q.duty[DUTY_W-1:FRAC_W]} + {{BASE_W{1'b0}}, ext_i};
    assign pwm_o  = ({1'b0, pos_i} < width);
    assign frac_o = st_q.duty[FRAC_W-1:0];

    // R5: working duty changes only on a boundary load
    a_r5_duty_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q.duty));
endmodule

// File: rtl/dither_pwm_chan.sv
module dither_pwm_chan
    import dpc_pkg::*;
#(
    parameter int unsigned BASE_W = DPC_BASE_W_DEF,
    parameter int unsigned FRAC_W = DPC_FRAC_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_en,
    input  logic                     sync_i,
    input  logic [BASE_W+FRAC_W-1:0] duty_in,
    output logic                     pwm_o,
    output logic [FRAC_W-1:0]        sub_idx_o
);
    logic [BASE_W-1:0] pos;
    logic [FRAC_W-1:0] sub;
    logic [FRAC_W-1:0] frac;
    logic              load;
    logic              ext;

    dpc_timebase #(.BASE_W(BASE_W), .FRAC_W(FRAC_W)) u_timebase (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .sync_i  (sync_i),
        .pos_o   (pos),
        .sub_o   (sub),
        .load_o  (load)
    );

    dpc_ratemul #(.FRAC_W(FRAC_W)) u_ratemul (
        .sub_i  (sub),
        .frac_i (frac),
        .ext_o  (ext)
    );

    dpc_shaper #(.BASE_W(BASE_W), .FRAC_W(FRAC_W)) u_shaper (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .duty_in (duty_in),
        .pos_i   (pos),
        .ext_i   (ext),
        .frac_o  (frac),
        .pwm_o   (pwm_o)
    );

    assign sub_idx_o = sub;

    // R8: last tick of subsection 0 is low, so no period is fully high
    a_r8_never_full: assert property (@(posedge clk) disable iff (!rst_n)
        (sub == '0 && pos == {BASE_W{1'b1}}) |-> !pwm_o);
endmodule

// File: tb/dither_pwm_chan_bench.sv
`timescale 1ns/1ps
module dither_pwm_chan_bench;
    localparam int BW   = 5;
    localparam int FW   = 4;
    localparam int DW   = BW + FW;
    localparam int TPS  = 1 << BW;
    localparam int NSUB = 1 << FW;
    localparam int TPC  = TPS * NSUB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          sync_i = 1'b0;
    logic [DW-1:0] duty_in = '0;
    logic          pwm_o;
    logic [FW-1:0] sub_idx_o;

    int n_chk = 0;
    int n_bad = 0;

    dither_pwm_chan #(.BASE_W(BW), .FRAC_W(FW)) u_dither_pwm_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .sync_i    (sync_i),
        .duty_in   (duty_in),
        .pwm_o     (pwm_o),
        .sub_idx_o (sub_idx_o)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_hi(input logic [DW-1:0] d, input logic [FW-1:0] m);
        bit e;
        e = (d[3] && m[0]) || (d[2] && m[1:0] == 2'd2) ||
            (d[1] && m[2:0] == 3'd4) || (d[0] && m == 4'd8);
        return int'(d[DW-1:FW]) + int'(e);
    endfunction

    // Tick-level reference model (R1, R2, R3, R5, R6 under random stimulus)
    int            m_pos = 0;
    int            m_sub = 0;
    logic [DW-1:0] m_duty = '0;

    always @(negedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_sub = 0; m_duty = '0;
        end else begin
            check(int'(sub_idx_o) == m_sub, "R1", int'(sub_idx_o), m_sub, "subsection index");
            check(pwm_o == (m_pos < exp_hi(m_duty, FW'(m_sub))), "R3", int'(pwm_o),
                  int'(m_pos < exp_hi(m_duty, FW'(m_sub))), "pwm level");
            if (tick_en) begin
                if (sync_i || (m_pos == TPS-1 && m_sub == NSUB-1)) begin
                    m_pos = 0; m_sub = 0; m_duty = duty_in;
                end else if (m_pos == TPS-1) begin
                    m_pos = 0; m_sub++;
                end else begin
                    m_pos++;
                end
            end
        end
    end

    // Restart, then count high ticks per subsection over two periods.
    task automatic run2(input logic [DW-1:0] d1, input logic [DW-1:0] d2, input int chg,
                        output int ca[NSUB], output int cb[NSUB]);
        for (int i = 0; i < NSUB; i++) begin ca[i] = 0; cb[i] = 0; end
        @(posedge clk); #1; duty_in = d1; tick_en = 1'b1; sync_i = 1'b1;
        @(posedge clk); #1; sync_i = 1'b0;
        for (int t = 0; t < 2*TPC; t++) begin
            if (t == chg) duty_in = d2;
            @(negedge clk);
            if (t == 0) check(sub_idx_o == '0, "R6", int'(sub_idx_o), 0, "index after restart");
            if (t < TPC) ca[sub_idx_o] += int'(pwm_o);
            else         cb[sub_idx_o] += int'(pwm_o);
            @(posedge clk); #1;
        end
    endtask

    task automatic chk_cycle(input int c[NSUB], input logic [DW-1:0] d, input string req);
        for (int m = 0; m < NSUB; m++)
            check(c[m] == exp_hi(d, FW'(m)), req, c[m], exp_hi(d, FW'(m)), $sformatf("high ticks sub %0d", m));
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        int ca[NSUB];
        int cb[NSUB];
        int hi;
        int total;
        logic [FW-1:0] s_sub;
        logic          s_pwm;
        logic [DW-1:0] d;

        void'($urandom(32'd4711));
        repeat (5) @(posedge clk);
        #1; rst_n = 1'b1; duty_in = 9'h1FF; tick_en = 1'b1;
        @(negedge clk);
        check(sub_idx_o == '0, "R7", int'(sub_idx_o), 0, "index after reset");
        check(pwm_o == 1'b0, "R7", int'(pwm_o), 0, "pwm after reset");
        // R7: first period uses working duty 0 regardless of duty_in
        hi = 0;
        for (int t = 0; t < TPC; t++) begin
            if (t > 0) @(negedge clk);
            hi += int'(pwm_o);
        end
        check(hi == 0, "R7", hi, 0, "high ticks in first period");

        // R4: the mid-scale example pattern and single dither weights
        d = {5'd10, 4'b0110}; run2(d, d, 0, ca, cb); chk_cycle(ca, d, "R4"); chk_cycle(cb, d, "R4");
        d = {5'd7, 4'b0001};  run2(d, d, 0, ca, cb); chk_cycle(ca, d, "R4");
        d = {5'd7, 4'b1000};  run2(d, d, 0, ca, cb); chk_cycle(ca, d, "R4");
        d = {5'd3, 4'b0010};  run2(d, d, 0, ca, cb); chk_cycle(ca, d, "R4");
        // R3: all-zero duty is low throughout
        d = '0;               run2(d, d, 0, ca, cb); chk_cycle(ca, d, "R3");
        // R8: largest value is still not full high
        d = {5'd31, 4'b1111}; run2(d, d, 0, ca, cb); chk_cycle(ca, d, "R8");
        total = 0;
        for (int m = 0; m < NSUB; m++) total += ca[m];
        check(total < TPC, "R8", total, TPC - 1, "high ticks in full-scale period");
        check(ca[0] == TPS - 1, "R8", ca[0], TPS - 1, "subsection 0 at full scale");
        // R8: no dither bits means identical subsections
        d = {5'd17, 4'b0000}; run2(d, d, 0, ca, cb); chk_cycle(ca, d, "R8");
        // R5: mid-period write waits for the boundary
        run2({5'd12, 4'b0101}, {5'd3, 4'b1010}, 200, ca, cb);
        chk_cycle(ca, {5'd12, 4'b0101}, "R5");
        chk_cycle(cb, {5'd3, 4'b1010}, "R5");

        // R2: freeze while high in subsection 0
        @(posedge clk); #1; duty_in = {5'd20, 4'b0000}; sync_i = 1'b1; tick_en = 1'b1;
        @(posedge clk); #1; sync_i = 1'b0;
        repeat (5) @(posedge clk);
        #1; tick_en = 1'b0;
        @(negedge clk); s_sub = sub_idx_o; s_pwm = pwm_o;
        repeat (9) @(posedge clk);
        @(negedge clk);
        check(sub_idx_o == s_sub, "R2", int'(sub_idx_o), int'(s_sub), "index with tick off");
        check(pwm_o == s_pwm && s_pwm == 1'b1, "R2", int'(pwm_o), 1, "pwm with tick off");

        // Random phase, checked by the model
        for (int i = 0; i < 40000; i++) begin
            @(posedge clk); #1;
            tick_en = 1'($urandom % 2);
            if ($urandom % 300 == 0) duty_in = DW'($urandom);
            sync_i = ($urandom % 3000 == 0);
        end
        @(posedge clk); #1; tick_en = 1'b0; sync_i = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule